// File: doc/BRIEF.md
# Hall-Sensor Commutation and Decay Selector

This block turns the three Hall sensor lines of a brushless DC motor, together with a rotation direction bit, into six gate-drive enables for a three-phase bridge. Each phase has one high-side enable and one low-side enable. For any legal rotor position, one phase is sourced through its high side and a second phase is sunk through its low side. The third phase floats.

During the off part of a PWM cycle, the block picks which low-side switches carry the recirculating current. The choice follows a decay-mode input. A supervisor can override everything with a brake command or a coast command. The Hall lines are asynchronous to the clock, so they are first synchronized. A one-clock step strobe marks each change of the synchronized Hall code, and a fault flag reports the two codes that no rotor position produces.

Phase indices are A=0, B=1 and C=2 in every three-bit gate vector. The Hall code is written H1 H2 H3, with H1 in bit 2 of `hall_in`. All outputs are registered.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir`=1 and `drive_on`=1, the code maps to a (high phase, low phase) pair as follows: 101→(A,C), 100→(B,C), 110→(B,A), 010→(C,A), 011→(C,B), 001→(A,B). Exactly that one bit is set in `gate_hi` and exactly that one bit in `gate_lo`.
- R2: With `dir`=0, each code selects the same two phases with the roles swapped. For example, 101 maps to (C high, A low).
- R3: With `slow_decay`=0 and `drive_on`=0 on a legal code, `gate_hi` is 0 and `gate_lo` has only the bit of the phase that would be high.
- R4: With `slow_decay`=1 and `drive_on`=0 on a legal code, `gate_hi` is 0 and `gate_lo` has the bits of both selected phases.
- R5: Codes 000 and 111 drive all six enables low and set `hall_fault`. `hall_fault` is 0 for legal codes.
- R6: With `ovr_brake`=1 and `ovr_coast`=0, `gate_lo`=111 and `gate_hi`=000. This holds whatever the Hall code, the decay mode or `drive_on`.
- R7: With `ovr_coast`=1, all six enables are low, even when `ovr_brake`=1.
- R8: `step_pulse` is high for exactly one clock each time the synchronized Hall code changes, including changes to or from an illegal code. It is low while the code is steady.
- R9: No output state ever has the high and low enables of one phase set together, and at most one high enable is set.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared on that edge.
- R11: A change on `dir`, `slow_decay`, `drive_on` or an override shows on the outputs one clock later. A change on `hall_in` shows three clocks later: two synchronizer stages plus the output register. `step_pulse` and `hall_fault` appear on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 3 | Raw Hall lines, H1 in bit 2, H3 in bit 0 |
| dir | input | 1 | Rotation direction |
| slow_decay | input | 1 | 1 selects slow decay, 0 selects fast decay |
| drive_on | input | 1 | PWM on-phase already gated by the current regulator |
| ovr_brake | input | 1 | Force all low sides on |
| ovr_coast | input | 1 | Force all enables off; wins over brake |
| gate_hi | output | 3 | High-side enables, bit 0 = phase A |
| gate_lo | output | 3 | Low-side enables, bit 0 = phase A |
| step_pulse | output | 1 | One-clock strobe on each synchronized Hall change |
| hall_fault | output | 1 | Illegal Hall code present |

## Verification
Two functions can fall in the same cycle: the step strobe and the output update caused by a Hall change. Both come out of the synchronizer on one edge, and a swap of the gate pair can also land on the clock where `drive_on` toggles.

The sweep changes the Hall code together with the direction, decay mode and drive level. It then checks, three edges later, that the strobe rises exactly where the new gate pattern first appears, and that the strobe is low one edge before and one edge after. Overrides are applied while the Hall code is illegal and while drive is on, to judge the priority order within a single cycle.

// File: rtl/bldc_pkg.sv
// Shared types and the commutation decode for the three-phase gate selector.
// Assumes phase index 0=A, 1=B, 2=C and Hall code bit 2 = H1.
package bldc_pkg;

    localparam int NPH  = 3;
    localparam int PIDX = 2;

    typedef logic [NPH-1:0] phase_vec_t;

    typedef struct packed {
        logic            valid;
        logic [PIDX-1:0] hp;   // phase sourced through its high side
        logic [PIDX-1:0] lp;   // phase sunk through its low side
    } pair_t;

    // Forward-direction pair for a Hall code; reverse swaps the roles.
    function automatic pair_t decode_hall(input logic [NPH-1:0] code, input logic fwd);
        pair_t p;
        p.valid = 1'b1;
        case (code)
            3'b101:  begin p.hp = 2'd0; p.lp = 2'd2; end
            3'b100:  begin p.hp = 2'd1; p.lp = 2'd2; end
            3'b110:  begin p.hp = 2'd1; p.lp = 2'd0; end
            3'b010:  begin p.hp = 2'd2; p.lp = 2'd0; end
            3'b011:  begin p.hp = 2'd2; p.lp = 2'd1; end
            3'b001:  begin p.hp = 2'd0; p.lp = 2'd1; end
            default: begin p.hp = 2'd0; p.lp = 2'd0; p.valid = 1'b0; end
        endcase
        if (!fwd) begin
            logic [PIDX-1:0] t;
            t    = p.hp;
            p.hp = p.lp;
            p.lp = t;
        end
        return p;
    endfunction

endpackage

// File: rtl/hall_sync.sv
// Multi-stage synchronizer for the Hall lines plus a change strobe.
// Assumes the raw lines are asynchronous; the strobe is registered, so it
// lines up with any logic registered off the last synchronizer stage.
module hall_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] code_o,
    output logic         step_o
);

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the asynchronous lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= raw_i;
            end
        end else begin : g_next
            // Shift one more stage to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign code_o = stg[STAGES-1];

    // Remember the last settled code and strobe when it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            step_o <= 1'b0;
        end else begin
            prev_q <= code_o;
            step_o <= (code_o != prev_q);
        end
    end

endmodule

// File: rtl/hall_decode.sv
// Combinational lookup from a settled Hall code and direction to the
// high/low phase pair; flags codes that no rotor position produces.
module hall_decode
    import bldc_pkg::*;
(
    input  logic [NPH-1:0] code_i,
    input  logic           dir_i,
    output pair_t          pair_o
);

    // Table lookup, direction applied as a role swap.
    always_comb begin
        pair_o = decode_hall(code_i, dir_i);
    end

endmodule

// File: rtl/gate_mux.sv
// Applies overrides, drive phase and decay mode to the decoded pair and
// registers the six enables and the fault flag.
// Priority: coast, brake, illegal code, then normal drive or decay.
module gate_mux
    import bldc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pair_t      pair_i,
    input  logic       drive_on_i,
    input  logic       slow_i,
    input  logic       brake_i,
    input  logic       coast_i,
    output phase_vec_t hi_o,
    output phase_vec_t lo_o,
    output logic       fault_o
);

    phase_vec_t hi_n, lo_n;

    // Select the next enable pattern from overrides, drive and decay.
    always_comb begin
        hi_n = '0;
        lo_n = '0;
        if (coast_i) begin
            hi_n = '0;
            lo_n = '0;
        end else if (brake_i) begin
            lo_n = '1;
        end else if (pair_i.valid) begin
            if (drive_on_i) begin
                hi_n[pair_i.hp] = 1'b1;
                lo_n[pair_i.lp] = 1'b1;
            end else begin
                lo_n[pair_i.hp] = 1'b1;
                if (slow_i) lo_n[pair_i.lp] = 1'b1;
            end
        end
    end

    // Register the enables and the fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o    <= '0;
            lo_o    <= '0;
            fault_o <= 1'b0;
        end else begin
            hi_o    <= hi_n;
            lo_o    <= lo_n;
            fault_o <= !pair_i.valid;
        end
    end

    assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_o & lo_o) == '0) && $onehot0(hi_o));

    assert_coast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        coast_i |=> (hi_o == '0 && lo_o == '0));

    assert_brake_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_i && !coast_i) |=> (hi_o == '0 && lo_o == '1));

    assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_i.valid && !brake_i && !coast_i) |=> (hi_o == '0 && lo_o == '0 && fault_o));

    assert_drive_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_i.valid && drive_on_i && !brake_i && !coast_i)
        |=> ($countones(hi_o) == 1 && $countones(lo_o) == 1));

endmodule

// File: rtl/bldc_commutator.sv
// Top: Hall synchronizer, commutation decode and gate selection.
// Assumes Hall lines are asynchronous and that dead time is inserted
// downstream of these enables.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_in,
    input  logic       dir,
    input  logic       slow_decay,
    input  logic       drive_on,
    input  logic       ovr_brake,
    input  logic       ovr_coast,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       step_pulse,
    output logic       hall_fault
);

    logic [NPH-1:0] code_s;
    pair_t          pair;

    hall_sync #(.W(NPH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (hall_in),
        .code_o (code_s),
        .step_o (step_pulse)
    );

    hall_decode u_dec (
        .code_i (code_s),
        .dir_i  (dir),
        .pair_o (pair)
    );

    gate_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_i     (pair),
        .drive_on_i (drive_on),
        .slow_i     (slow_decay),
        .brake_i    (ovr_brake),
        .coast_i    (ovr_coast),
        .hi_o       (gate_hi),
        .lo_o       (gate_lo),
        .fault_o    (hall_fault)
    );

endmodule

// File: tb/bldc_commutator_tb.sv
module bldc_commutator_tb;

    localparam int HALL_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b101;
    logic       dir = 1'b1, slow_decay = 1'b0, drive_on = 1'b0;
    logic       ovr_brake = 1'b0, ovr_coast = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic       step_pulse, hall_fault;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    bldc_commutator u_dut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir(dir),
        .slow_decay(slow_decay), .drive_on(drive_on), .ovr_brake(ovr_brake),
        .ovr_coast(ovr_coast), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .step_pulse(step_pulse), .hall_fault(hall_fault)
    );

    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // R9 watched on every cycle after reset.
    always @(negedge clk) begin
        if (mon_on) begin
            chk(((gate_hi & gate_lo) == 3'b0) && ($countones(gate_hi) <= 1), "R9",
                {2'b0, gate_hi, gate_lo}, 8'h0);
        end
    end

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] prev;
        drive_on = 1'b1;
        cyc(3);
        chk({gate_hi, gate_lo, step_pulse, hall_fault} == 8'h0, "R10 reset",
            {gate_hi, gate_lo, step_pulse, hall_fault}, 8'h0);
        rst_n = 1'b1;
        cyc(6);
        mon_on = 1'b1;
        prev = 3'b101;
        // Sweep over direction, decay mode, drive level and all legal codes.
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
                for (int dr = 0; dr < 2; dr++)
                    for (int k = 0; k < 6; k++) begin
                        int hp, lp, t;
                        logic [2:0] eh, el;
                        hp = ((k + 1) / 2) % 3;
                        lp = ((k / 2) + 2) % 3;
                        if (d == 0) begin t = hp; hp = lp; lp = t; end
                        eh = dr ? 3'(1 << hp) : 3'b0;
                        el = dr ? 3'(1 << lp) : (m ? 3'((1 << hp) | (1 << lp)) : 3'(1 << hp));
                        dir = d[0]; slow_decay = m[0]; drive_on = dr[0];
                        hall_in = seq[k];
                        cyc(HALL_LAT - 1);
                        chk(step_pulse == 1'b0, "R11 strobe early", {7'b0, step_pulse}, 8'h0);
                        cyc(1);
                        chk({gate_hi, gate_lo} == {eh, el},
                            d ? (dr ? "R1 fwd pair" : (m ? "R4 slow decay" : "R3 fast decay"))
                              : (dr ? "R2 rev pair" : (m ? "R4 slow decay" : "R3 fast decay")),
                            {2'b0, gate_hi, gate_lo}, {2'b0, eh, el});
                        chk(step_pulse == (seq[k] != prev), "R8 strobe",
                            {7'b0, step_pulse}, {7'b0, seq[k] != prev});
                        chk(hall_fault == 1'b0, "R5 no fault", {7'b0, hall_fault}, 8'h0);
                        cyc(1);
                        chk(step_pulse == 1'b0, "R8 one clock", {7'b0, step_pulse}, 8'h0);
                        prev = seq[k];
                    end
        // Illegal codes with drive on.
        dir = 1'b1; drive_on = 1'b1;
        hall_in = 3'b000;
        cyc(HALL_LAT);
        chk({gate_hi, gate_lo, hall_fault, step_pulse} == 8'b00000011, "R5 code 000",
            {gate_hi, gate_lo, hall_fault, step_pulse}, 8'b00000011);
        hall_in = 3'b111;
        cyc(HALL_LAT);
        chk({gate_hi, gate_lo, hall_fault} == 7'b0000001, "R5 code 111",
            {1'b0, gate_hi, gate_lo, hall_fault}, 8'b00000001);
        // Brake while the code is illegal, one clock latency.
        ovr_brake = 1'b1;
        cyc(1);
        chk({gate_hi, gate_lo} == 6'b000111, "R6 brake illegal", {2'b0, gate_hi, gate_lo}, 8'b000111);
        hall_in = 3'b110;
        cyc(HALL_LAT);
        chk({gate_hi, gate_lo} == 6'b000111, "R6 brake drive", {2'b0, gate_hi, gate_lo}, 8'b000111);
        ovr_coast = 1'b1;
        cyc(1);
        chk({gate_hi, gate_lo} == 6'b0, "R7 coast over brake", {2'b0, gate_hi, gate_lo}, 8'h0);
        ovr_brake = 1'b0;
        cyc(1);
        chk({gate_hi, gate_lo} == 6'b0, "R7 coast", {2'b0, gate_hi, gate_lo}, 8'h0);
        ovr_coast = 1'b0;
        cyc(1);
        chk({gate_hi, gate_lo} == 6'b010001, "R11 control latency", {2'b0, gate_hi, gate_lo}, 8'b010001);
        slow_decay = 1'b1; drive_on = 1'b0;
        cyc(1);
        chk({gate_hi, gate_lo} == 6'b000011, "R4 slow decay", {2'b0, gate_hi, gate_lo}, 8'b000011);
        // Reset in mid-run clears everything on the edge.
        rst_n = 1'b0;
        mon_on = 1'b0;
        cyc(1);
        chk({gate_hi, gate_lo, step_pulse, hall_fault} == 8'h0, "R10 reset again",
            {gate_hi, gate_lo, step_pulse, hall_fault}, 8'h0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule